// File: doc/BRIEF.md
# Modem Status Register

This block holds the modem status register of a 16550-style serial port. Four modem control lines (clear-to-send, data-set-ready, ring indicator, carrier detect) arrive asynchronously and are passed through a multi-flop synchronizer. The upper nibble of the register shows the synchronized level of each line. The lower nibble holds sticky change flags, which the host clears by reading the register.

A modem-status interrupt request is raised while that interrupt is enabled and at least one counted change flag is set. When automatic CTS flow control is switched on, a CTS change still sets its flag, but that flag no longer counts toward the interrupt. The host reads the register value on the same cycle that it pulses the read strobe. The flags clear on the clock edge that ends the read cycle.

Top module: `modem_status_top`

## Requirements
- R1: After reset the register reads 0x00 and the interrupt request is low.
- R2: Bit 7 shows the carrier-detect level, bit 6 ring indicator, bit 5 data-set-ready and bit 4 clear-to-send. A level applied at a pin before clock edge k is visible after edge k+2.
- R3: Bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) are set on any change of their line. Each flag is set on the same edge that updates the matching level bit.
- R4: Bit 2 is set only when the ring indicator goes from high to low. A low-to-high ring transition leaves bit 2 unchanged.
- R5: A read strobe returns the current value in its own cycle and clears bits 3:0 at the edge that ends that cycle.
- R6: A change whose flag would be set on the edge that ends a read cycle is kept: that flag reads 1 after the read.
- R7: Without a read, change flags stay set.
- R8: With the interrupt enable high, the interrupt request is high in any cycle in which a counted change flag is set, and low otherwise.
- R9: With the interrupt enable low, the interrupt request is low, while the flags still set as in R3 and R4.
- R10: With auto-CTS mode high, bit 0 no longer counts toward the interrupt request but still sets. Bits 1 to 3 still count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| ri_i | input | 1 | Ring indicator line, asynchronous |
| dcd_i | input | 1 | Carrier detect line, asynchronous |
| rd_stb_i | input | 1 | Host read of the register, one cycle per read |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| auto_cts_i | input | 1 | Automatic CTS flow-control mode |
| msr_o | output | 8 | Register value: levels in 7:4, change flags in 3:0 |
| msi_irq_o | output | 1 | Modem-status interrupt request |

## Verification
Two events can fall in the same cycle: a host read that clears the flags, and a new line change whose flag is being set. The bench provokes this by toggling a line two cycles before it pulses the read strobe. The flag then must read 1 after the read, while flags for the other lines read 0. The same reference model, which runs every cycle, also covers the auto-CTS case, in which a CTS flag is set while the interrupt stays low.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int LINES   = 4;
    localparam int REG_W   = 2 * LINES;

    // Line index inside every nibble; the register layout depends on it.
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;

    typedef struct packed {
        logic [LINES-1:0] lvl;
        logic [LINES-1:0] dlt;
    } msr_state_t;

    typedef enum logic [1:0] {
        EDGE_ANY  = 2'd0,
        EDGE_FALL = 2'd1
    } edge_kind_e;

    function automatic edge_kind_e kind_of(input int line);
        return (line == IDX_RI) ? EDGE_FALL : EDGE_ANY;
    endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_line
            logic [STAGES-1:0] chain_d;
            logic [STAGES-1:0] chain_q;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], async_i[g]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end

            assign sync_o[g] = chain_q[LAST];

            // R2: the first stage captures the pin on each edge
            a_r2_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> chain_q[0] == $past(async_i[g]));
        end
    endgenerate

endmodule

// File: rtl/msr_detect.sv
module msr_detect
    import msr_pkg::*;
(
    input  logic [LINES-1:0] cur_i,
    input  logic [LINES-1:0] prev_i,
    output logic [LINES-1:0] evt_o
);

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_evt
            if (kind_of(g) == EDGE_FALL) begin : g_fall
                always_comb evt_o[g] = prev_i[g] & ~cur_i[g];
            end else begin : g_any
                always_comb evt_o[g] = prev_i[g] ^ cur_i[g];
            end
        end
    endgenerate

endmodule

// File: rtl/msr_irq.sv
module msr_irq
    import msr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] dlt_i,
    input  logic             en_i,
    input  logic             auto_cts_i,
    output logic             irq_o
);

    logic [LINES-1:0] mask;

    always_comb begin
        mask          = '1;
        mask[IDX_CTS] = ~auto_cts_i;
        irq_o         = en_i & (|(dlt_i & mask));
    end

    // R9: disabled interrupt never requests
    a_r9_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !irq_o);
    // R8: a non-CTS flag with the enable set always requests
    a_r8_request: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (dlt_i[IDX_DSR] || dlt_i[IDX_RI] || dlt_i[IDX_DCD])) |-> irq_o);
    // R10: under auto-CTS a lone CTS flag raises nothing
    a_r10_auto_cts: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts_i && !dlt_i[IDX_DSR] && !dlt_i[IDX_RI] && !dlt_i[IDX_DCD]) |-> !irq_o);

endmodule

// File: rtl/modem_status_top.sv
module modem_status_top
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cts_i,
    input  logic             dsr_i,
    input  logic             ri_i,
    input  logic             dcd_i,
    input  logic             rd_stb_i,
    input  logic             msi_en_i,
    input  logic             auto_cts_i,
    output logic [REG_W-1:0] msr_o,
    output logic             msi_irq_o
);

    logic [LINES-1:0] pins;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] evt;
    msr_state_t       st_d;
    msr_state_t       st_q;

    always_comb begin
        pins          = '0;
        pins[IDX_CTS] = cts_i;
        pins[IDX_DSR] = dsr_i;
        pins[IDX_RI]  = ri_i;
        pins[IDX_DCD] = dcd_i;
    end

    msr_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins),
        .sync_o  (synced)
    );

    msr_detect u_detect (
        .cur_i  (synced),
        .prev_i (st_q.lvl),
        .evt_o  (evt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.lvl = synced;
        st_d.dlt = (rd_stb_i ? '0 : st_q.dlt) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msr_o = st_q;

    msr_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dlt_i      (st_q.dlt),
        .en_i       (msi_en_i),
        .auto_cts_i (auto_cts_i),
        .irq_o      (msi_irq_o)
    );

    // R5/R6: after a read only fresh events remain flagged
    a_r6_read_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rd_stb_i) |-> msr_o[LINES-1:0] == $past(evt));
    // R7: flags are sticky without a read
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(rd_stb_i) |->
            (msr_o[LINES-1:0] & $past(msr_o[LINES-1:0])) == $past(msr_o[LINES-1:0]));
    // R4: a rising ring line never sets the ring flag
    a_r4_ri_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rd_stb_i) && $rose(msr_o[LINES+IDX_RI]) |-> !msr_o[IDX_RI]);
    // R3: a level change of a toggle-sensitive line sets its flag
    a_r3_dcd_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (msr_o[LINES+IDX_DCD] != $past(msr_o[LINES+IDX_DCD])) |-> msr_o[IDX_DCD]);

endmodule

// File: tb/sim_modem_status_top.sv
module sim_modem_status_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts = 0, dsr = 0, ri = 0, dcd = 0;
    logic       rd = 0, ie = 0, ac = 0;
    logic [7:0] msr;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    modem_status_top u0 (
        .clk(clk), .rst_n(rst_n), .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd),
        .rd_stb_i(rd), .msi_en_i(ie), .auto_cts_i(ac), .msr_o(msr), .msi_irq_o(irq)
    );

    // behavioural reference: pin history queue plus sticky flag word
    logic [3:0] hist [$];
    logic [3:0] m_lvl = 0, m_dlt = 0;

    always @(posedge clk) begin
        logic [3:0] seen;
        logic [3:0] ev;
        if (!rst_n) begin
            hist = {4'h0, 4'h0};
            m_lvl = 0; m_dlt = 0;
        end else begin
            seen = hist[0];
            ev = 0;
            for (int i = 0; i < 4; i++)
                ev[i] = (i == 2) ? (m_lvl[i] && !seen[i]) : (m_lvl[i] != seen[i]);
            m_dlt = (rd ? 4'h0 : m_dlt) | ev;
            m_lvl = seen;
            void'(hist.pop_front());
            hist.push_back({dcd, ri, dsr, cts});
        end
    end

    function automatic logic exp_irq();
        logic [3:0] mk;
        mk = ac ? 4'b1110 : 4'b1111;
        return ie && ((m_dlt & mk) != 0);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // compare on every falling edge, then step inputs
    task automatic step();
        @(negedge clk);
        check({phase, " msr"}, {24'h0, msr}, {24'h0, m_lvl, m_dlt});
        check({phase, " irq"}, {31'h0, irq}, {31'h0, exp_irq()});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_read();
        rd = 1; step(); rd = 0;
    endtask

    initial begin : watchdog
        #800000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        check("R1 reset msr", {24'h0, msr}, 32'h0);
        check("R1 reset irq", {31'h0, irq}, 32'h0);
        rst_n = 1;
        idle(2);

        phase = "R2 R3";
        cts = 1; step(); step(); step();
        check("R2 cts level", {31'h0, msr[4]}, 32'h1);
        check("R3 cts flag", {31'h0, msr[0]}, 32'h1);
        dcd = 1; dsr = 1; idle(4);
        check("R3 dcd dsr flags", {28'h0, msr[3:0]}, 32'hB);

        phase = "R7";
        idle(5);
        check("R7 sticky", {28'h0, msr[3:0]}, 32'hB);

        phase = "R5";
        do_read(); step();
        check("R5 cleared", {28'h0, msr[3:0]}, 32'h0);

        phase = "R4";
        ri = 1; idle(5);
        check("R4 rise no flag", {31'h0, msr[2]}, 32'h0);
        ri = 0; idle(5);
        check("R4 fall flag", {31'h0, msr[2]}, 32'h1);
        do_read(); step();

        phase = "R6";
        dsr = 0; step(); step(); do_read();
        check("R6 event kept", {28'h0, msr[3:0]}, 32'h2);
        do_read(); step();

        phase = "R9";
        ie = 0; dcd = 0; idle(5);
        check("R9 no irq", {31'h0, irq}, 32'h0);
        phase = "R8";
        ie = 1; step();
        check("R8 irq", {31'h0, irq}, 32'h1);
        do_read(); step();
        check("R8 irq drops", {31'h0, irq}, 32'h0);

        phase = "R10";
        ac = 1; cts = 0; idle(5);
        check("R10 cts flag set", {31'h0, msr[0]}, 32'h1);
        check("R10 no irq", {31'h0, irq}, 32'h0);
        dcd = 1; idle(5);
        check("R10 dcd irq", {31'h0, irq}, 32'h1);
        do_read(); ac = 0;

        phase = "R3 R8 mixed";
        for (int k = 0; k < 3000; k++) begin
            {dcd, ri, dsr, cts} = ($urandom % 5 == 0) ? 4'($urandom) : {dcd, ri, dsr, cts};
            rd = ($urandom % 7 == 0);
            ie = ($urandom % 4 != 0);
            ac = ($urandom % 3 == 0);
            step();
        end
        rd = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule